// File: doc/BRIEF.md
# Single-Level Page Translation Unit

This block turns a logical address into a physical address through a page table kept in on-block storage. The logical address is divided into a page number (upper bits) and an in-page offset (lower bits). The page number selects one table entry. The entry carries a presence flag and a frame number. When the flag is set, the physical address is the frame number with the untouched offset placed beneath it. When the flag is clear, the page lies outside the address space and the access is reported as a fault.

Software fills the table through a one-entry-per-cycle write port. Lookups use a simple request/response handshake with a fixed latency of one cycle. After reset every entry reads as absent, so a page must be written before it translates. Several entries may name the same frame, which lets pages be shared.

Top module: `pgx_xlate`

## Requirements
- R1: The page number is `req_laddr[18:10]` and the offset is `req_laddr[9:0]`. Both are taken as plain bit fields, with no arithmetic. Pages 0 and 511 and offsets 0 and 1023 translate like any others.
- R2: A table entry written through `wr_entry` uses bit 15 as the presence flag (1 = present) and bits 14:0 as the frame number. The entry is written at index `wr_idx` when `wr_en` is 1.
- R3: For a present entry, `resp_paddr` equals {frame[14:0], offset[9:0]} (25 bits) and `resp_fault` is 0.
- R4: For an absent entry, `resp_fault` is 1 and `resp_paddr` is 0.
- R5: `resp_valid` is 1 in the cycle after a cycle with `req_valid` = 1, and 0 otherwise. While `resp_valid` is 0, both `resp_paddr` and `resp_fault` are 0.
- R6: A reset (`rst_n` low at a clock edge) clears every presence flag and `resp_valid`. Pages written before the reset fault afterwards.
- R7: When a write and a lookup hit the same index in the same cycle, the lookup returns the contents from before the write. The next lookup sees the new contents.
- R8: Two or more entries may hold the same frame number, and each of them translates to that frame.
- R9: Writing an entry with bit 15 = 0 makes that page fault on later lookups, even if it was present before.
- R10: A value on `wr_idx`/`wr_entry` while `wr_en` is 0 leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 9 | Index of the entry to write |
| wr_entry | input | 16 | Entry value: bit 15 presence flag, bits 14:0 frame |
| req_valid | input | 1 | Lookup request strobe |
| req_laddr | input | 19 | Logical address to translate |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_paddr | output | 25 | Physical address, or 0 on a fault |
| resp_fault | output | 1 | Set when the addressed entry is absent |

## Verification
The hardest case to reach from the ports is a write and a lookup landing on the same index in the same clock. That case is the only place where the ordering of the table update against the read can be seen. The stimulus creates it on purpose in several forms:
- absent to present,
- present to a different frame,
- present to absent.

Each collision is followed by a repeat lookup, so both the old and the new contents are observed. A reset issued in the middle of a run, after many pages have been filled, exercises the clearing of the presence flags on a populated table.

// File: rtl/pgx_pkg.sv
// Package: default geometry of the translation unit.
// Assumes: a page size that is a power of two, so the fields are plain bit slices.
package pgx_pkg;
    localparam int PGX_PN_W  = 9;   // page-number field width
    localparam int PGX_OFF_W = 10;  // in-page offset width
    localparam int PGX_FRM_W = 15;  // frame-number width
endpackage

// File: rtl/pgx_split.sv
// Module: pgx_split
// Splits a logical address into page number and offset.
// Assumes: the offset occupies the low OFF_W bits; no arithmetic is needed.
module pgx_split #(
    parameter int PN_W  = 9,
    parameter int OFF_W = 10,
    localparam int LA_W = PN_W + OFF_W
) (
    input  logic [LA_W-1:0]  laddr,
    output logic [PN_W-1:0]  page,
    output logic [OFF_W-1:0] offset
);
    // field extraction
    always_comb begin
        page   = laddr[LA_W-1:OFF_W];
        offset = laddr[OFF_W-1:0];
    end
endmodule

// File: rtl/pgx_table.sv
// Module: pgx_table
// Page table storage: one presence flag (resettable) and one frame per entry.
// Assumes: one write and one read per cycle; the read is registered and sees
// the contents from before a same-cycle write.
module pgx_table #(
    parameter int PN_W  = 9,
    parameter int FRM_W = 15,
    localparam int DEPTH = 1 << PN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PN_W-1:0]  wr_idx,
    input  logic             wr_vld,
    input  logic [FRM_W-1:0] wr_frame,
    input  logic             rd_en,
    input  logic [PN_W-1:0]  rd_idx,
    output logic             rd_vld_q,
    output logic [FRM_W-1:0] rd_frame_q
);
    logic [DEPTH-1:0] vld_q;
    logic [FRM_W-1:0] frame_mem [DEPTH];

    // presence flags: cleared on reset, updated by writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= wr_vld;
        end
    end

    // frame storage: no reset, only meaningful when the flag is set
    always_ff @(posedge clk) begin
        if (wr_en) begin
            frame_mem[wr_idx] <= wr_frame;
        end
    end

    // registered read returning pre-write contents
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld_q   <= 1'b0;
            rd_frame_q <= '0;
        end else if (rd_en) begin
            rd_vld_q   <= vld_q[rd_idx];
            rd_frame_q <= frame_mem[rd_idx];
        end
    end

    // R6
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (vld_q == '0));

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (vld_q[$past(wr_idx)] == $past(wr_vld)));

    // R10
    no_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(vld_q));
endmodule

// File: rtl/pgx_resp.sv
// Module: pgx_resp
// Forms the response one cycle after the request from the table read and the
// registered offset.
// Assumes: the entry read arrives in the same cycle as the registered offset.
module pgx_resp #(
    parameter int OFF_W = 10,
    parameter int FRM_W = 15,
    localparam int PA_W = FRM_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [OFF_W-1:0] offset,
    input  logic             ent_vld,
    input  logic [FRM_W-1:0] ent_frame,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_fault
);
    logic             pend_q;
    logic [OFF_W-1:0] off_q;

    // request tracking and offset capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            off_q  <= '0;
        end else begin
            pend_q <= req_valid;
            if (req_valid) begin
                off_q <= offset;
            end
        end
    end

    // response assembly: concatenate on hit, zero on fault or idle
    always_comb begin
        resp_valid = pend_q;
        resp_fault = pend_q && !ent_vld;
        resp_paddr = (pend_q && ent_vld) ? {ent_frame, off_q} : '0;
    end

    // R5
    resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!resp_valid && !resp_fault && resp_paddr == '0));

    // R4
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fault |-> (resp_valid && resp_paddr == '0));
endmodule

// File: rtl/pgx_xlate.sv
// Module: pgx_xlate (top)
// Single-level page translation: logical address -> physical address or fault.
// Assumes: entry format {present, frame}; synchronous active-low reset.
module pgx_xlate
    import pgx_pkg::*;
#(
    parameter int PN_W  = PGX_PN_W,
    parameter int OFF_W = PGX_OFF_W,
    parameter int FRM_W = PGX_FRM_W,
    localparam int LA_W  = PN_W + OFF_W,
    localparam int PA_W  = FRM_W + OFF_W,
    localparam int ENT_W = FRM_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PN_W-1:0]  wr_idx,
    input  logic [ENT_W-1:0] wr_entry,
    input  logic             req_valid,
    input  logic [LA_W-1:0]  req_laddr,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_fault
);
    logic [PN_W-1:0]  req_page;
    logic [OFF_W-1:0] req_off;
    logic             ent_vld;
    logic [FRM_W-1:0] ent_frame;

    pgx_split #(.PN_W(PN_W), .OFF_W(OFF_W)) u_split (
        .laddr  (req_laddr),
        .page   (req_page),
        .offset (req_off)
    );

    pgx_table #(.PN_W(PN_W), .FRM_W(FRM_W)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_vld     (wr_entry[ENT_W-1]),
        .wr_frame   (wr_entry[FRM_W-1:0]),
        .rd_en      (req_valid),
        .rd_idx     (req_page),
        .rd_vld_q   (ent_vld),
        .rd_frame_q (ent_frame)
    );

    pgx_resp #(.OFF_W(OFF_W), .FRM_W(FRM_W)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .offset     (req_off),
        .ent_vld    (ent_vld),
        .ent_frame  (ent_frame),
        .resp_valid (resp_valid),
        .resp_paddr (resp_paddr),
        .resp_fault (resp_fault)
    );

    // R3
    offset_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid |=> (resp_fault ||
            resp_paddr[OFF_W-1:0] == $past(req_laddr[OFF_W-1:0]))));
endmodule

// File: tb/pgx_xlate_tb.sv
module pgx_xlate_tb;
    localparam int PN_W  = 9;
    localparam int OFF_W = 10;
    localparam int FRM_W = 15;
    localparam int LA_W  = PN_W + OFF_W;
    localparam int PA_W  = FRM_W + OFF_W;
    localparam int DEPTH = 1 << PN_W;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [PN_W-1:0] wr_idx = '0;
    logic [15:0]     wr_entry = '0;
    logic            req_valid = 1'b0;
    logic [LA_W-1:0] req_laddr = '0;
    logic            resp_valid;
    logic [PA_W-1:0] resp_paddr;
    logic            resp_fault;

    int total = 0;
    int bad   = 0;
    string tag = "R6";

    // reference model state
    bit ref_v [DEPTH];
    int ref_f [DEPTH];
    bit have_exp = 0;
    bit exp_rv, exp_fault;
    longint exp_pa;

    always #4 clk = ~clk;

    pgx_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_entry(wr_entry), .req_valid(req_valid), .req_laddr(req_laddr),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault)
    );

    task automatic check();
        total++;
        if (resp_valid !== exp_rv || resp_fault !== exp_fault ||
            longint'(resp_paddr) != exp_pa || $isunknown(resp_paddr)) begin
            bad++;
            $display("FAIL %s: got v=%0b f=%0b pa=%h, expected v=%0b f=%0b pa=%h",
                     tag, resp_valid, resp_fault, resp_paddr, exp_rv, exp_fault, exp_pa);
        end
    endtask

    // one cycle: check previous expectation, drive new inputs, predict
    task automatic step(input bit r, input bit we, input int wi, input bit wv,
                        input int wf, input bit rv, input int la);
        int pn, off;
        @(negedge clk);
        if (have_exp) check();
        rst_n     = r;
        wr_en     = we;
        wr_idx    = wi[PN_W-1:0];
        wr_entry  = {wv, wf[FRM_W-1:0]};
        req_valid = rv;
        req_laddr = la[LA_W-1:0];
        exp_fault = 0;
        exp_pa    = 0;
        if (!r) begin
            exp_rv = 0;
            for (int i = 0; i < DEPTH; i++) ref_v[i] = 0;
        end else begin
            exp_rv = rv;
            pn  = (la >> OFF_W) & (DEPTH - 1);
            off = la & ((1 << OFF_W) - 1);
            if (rv) begin
                if (ref_v[pn]) exp_pa = (longint'(ref_f[pn]) << OFF_W) | off;
                else exp_fault = 1;
            end
            if (we) begin
                ref_v[wi & (DEPTH - 1)] = wv;
                ref_f[wi & (DEPTH - 1)] = wf & ((1 << FRM_W) - 1);
            end
        end
        have_exp = 1;
    endtask

    function automatic int la_of(int pg, int off);
        return (pg << OFF_W) | off;
    endfunction

    task automatic put(int pg, bit v, int fr);
        step(1, 1, pg, v, fr, 0, 0);
    endtask

    task automatic look(int pg, int off);
        step(1, 0, 0, 0, 0, 1, la_of(pg, off));
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        summary();
    end

    initial begin
        // R6: reset state, requests during reset produce nothing
        tag = "R6";
        for (int i = 0; i < 4; i++) step(0, 1, i, 1, 7, 1, la_of(i, 3));
        for (int i = 0; i < 6; i++) look(i * 97, i);
        // R4: unwritten pages fault with zero address
        tag = "R4";
        look(0, 0); look(511, 1023); look(200, 55);
        // R10: writes without strobe are ignored
        tag = "R10";
        step(1, 0, 5, 1, 1234, 0, 0);
        step(1, 0, 6, 1, 99, 1, la_of(5, 17));
        look(5, 17); look(6, 0);
        // R2 / R3: fill entries and translate
        tag = "R2";
        put(1, 1, 15'h1234); put(2, 1, 15'h7FFF); put(3, 1, 0);
        look(1, 100); look(2, 1023); look(3, 0);
        // R1: field boundaries
        tag = "R1";
        put(0, 1, 15'h0ABC); put(511, 1, 15'h5555);
        look(0, 0); look(0, 1023); look(511, 0); look(511, 1023);
        // R8: shared frames
        tag = "R8";
        put(40, 1, 777); put(41, 1, 777); put(300, 1, 777);
        look(40, 1); look(41, 2); look(300, 3);
        // R7: same-cycle write and lookup to one index
        tag = "R7";
        step(1, 1, 50, 1, 4321, 1, la_of(50, 9));  // absent -> present
        look(50, 9);
        step(1, 1, 50, 1, 22, 1, la_of(50, 10));   // frame change
        look(50, 10);
        step(1, 1, 50, 0, 0, 1, la_of(50, 11));    // present -> absent
        look(50, 11);
        // R9: invalidate by write with flag clear
        tag = "R9";
        put(1, 0, 15'h1234);
        look(1, 100); look(2, 5);
        // R5: gaps and back-to-back requests
        tag = "R5";
        step(1, 0, 0, 0, 0, 0, la_of(2, 1));
        step(1, 0, 0, 0, 0, 0, 0);
        look(2, 7); look(0, 8); look(9, 9);
        step(1, 0, 0, 0, 0, 0, la_of(2, 1));
        // R3: random mix of writes and lookups
        tag = "R3";
        for (int i = 0; i < 3000; i++) begin
            step(1, ($urandom % 3) == 0, $urandom % DEPTH, ($urandom % 4) != 0,
                 $urandom, ($urandom % 4) != 0, $urandom);
        end
        // R6: reset on a populated table
        tag = "R6";
        step(0, 0, 0, 0, 0, 1, la_of(2, 1));
        step(0, 0, 0, 0, 0, 0, 0);
        look(2, 1); look(0, 0); look(511, 1023); look(40, 1);
        step(1, 0, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0, 0);
        summary();
    end
endmodule